// File: doc/BRIEF.md
# SAR ADC Host Readout Controller

This block sits on the host side of an 18-bit successive-approximation converter that is run in chip-select mode with a busy indicator. A one-cycle `start` pulse makes the controller raise the convert line while the select line is high, which puts the converter in chip-select mode and begins a conversion. After a programmable number of cycles the select line is pulled low, and the controller watches the converter's data line. That line idles high through an external pull-up and is driven low when the conversion ends.

Once the data line goes low, the controller generates 18 serial clock pulses from the system clock through a programmable divider. It samples one result bit per pulse, most significant bit first. It then raises the select line, drops the convert line on the next cycle, and presents the assembled word with a one-cycle `valid` strobe.

If the data line is still high after a programmable number of cycles, the transaction is abandoned. The controller produces no serial clock, runs the same release sequence, and pulses `error` instead of `valid`.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `cnv`=0, `sdi`=1, `sck`=0, `busy`=0, `valid`=0 and `error`=0.
- R2: A `start` pulse seen while idle makes `cnv` rise on the next clock edge with `sdi` already high, and `busy` goes to 1 at that same edge. A `start` seen while a transaction is running is ignored and produces no extra result.
- R3: After `cnv` rises, `sdi` stays high for exactly `cfg_sdi_hold` clock cycles (minimum 1). It then stays low until all 18 bits have been read.
- R4: A low level on `sdo` is recognised as completion only after `sdi` has gone low. A low level during the `sdi`-high window does not start a readout.
- R5: The first `sck` rising edge comes on the clock edge that first sees `sdo` low in the wait phase. Every high phase and every low phase of `sck` lasts `cfg_half` clock cycles, and a value of 0 acts as 1. Exactly 18 pulses are issued, and `sck` is 0 outside them.
- R6: The converter launches a new bit on each falling `sck` edge. The controller samples `sdo` at the end of each low phase. The first bit sampled becomes `result[17]` and the last becomes `result[0]`.
- R7: `cnv` stays high from the start until one cycle after `sdi` has returned high. `sdi` rises on the edge of the last sample, `cnv` falls one edge later, and `valid` is high for exactly one cycle one edge after that. This places `valid` 36·`cfg_half`+2 edges after the edge that saw `sdo` low.
- R8: If `sdo` is still high when `cfg_conv_max` cycles have passed since `cnv` rose, no `sck` pulse is issued. `sdi` rises on edge `cfg_conv_max` after the start edge, `cnv` falls one edge later, and `error` is high for one cycle one edge after that. `valid` stays 0.
- R9: `busy` is 0 in the cycle in which `valid` or `error` is high and while idle. A new `start` is accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request one conversion and readout |
| cfg_sdi_hold | input | CNT_W | Cycles that `sdi` stays high after `cnv` rises |
| cfg_conv_max | input | CNT_W | Cycles allowed from `cnv` rising to `sdo` falling |
| cfg_half | input | DIV_W | `sck` half period in clock cycles (0 acts as 1) |
| busy | output | 1 | Transaction in progress |
| valid | output | 1 | One-cycle strobe: `result` holds a new word |
| error | output | 1 | One-cycle strobe: conversion timed out |
| result | output | DATA_W | Last word read, MSB first on the wire |
| cnv | output | 1 | Convert line to the converter |
| sdi | output | 1 | Select line to the converter |
| sck | output | 1 | Serial clock to the converter |
| sdo | input | 1 | Converter data line (pulled up when released) |

## Verification
A good readout ends with `valid` 36·`cfg_half`+2 edges after the edge that first sees `sdo` low. A timed-out one ends with `error` `cfg_conv_max`+2 edges after the edge that accepted `start`. Each pushed expectation carries that latency together with the word, and the monitor compares it against a free-running cycle count measured from the moment the device model released `sdo` low, or from the `start` cycle for a timeout. The `sdi`-high window and the total number of `sck`-high cycles (18·`cfg_half`) are counted at the falling clock edge. All outputs are sampled half a period away from the edge that updates them.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,    // cnv low, sdi high, waiting for start
    ST_SEL,     // cnv high, sdi high for the programmed hold
    ST_WAIT,    // sdi low, watching the data line for completion
    ST_READ,    // generating serial clock, collecting bits
    ST_RELSDI,  // sdi back high, cnv still high
    ST_DROP,    // cnv low
    ST_DONE     // result or error strobe
  } rd_state_t;

endpackage

// File: rtl/sar_rd_timer.sv
module sar_rd_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // saturating up-counter; clear wins over enable
  always_comb begin
    cnt_d = cnt_q;
    if (clr)                    cnt_d = '0;
    else if (en && cnt_q != '1) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sar_rd_clkdiv.sv
module sar_rd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half_eff;

  assign half_eff = (half == '0) ? DIV_W'(1) : half;
  assign tick     = en && (cnt_q == half_eff - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sar_rd_shreg.sv
module sar_rd_shreg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              din,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_q, q_d;

  // first bit in ends up in the top position
  always_comb begin
    q_d = q_q;
    if (en) q_d = {q_q[DATA_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int CNT_W  = 12,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_sdi_hold,
  input  logic [CNT_W-1:0]  cfg_conv_max,
  input  logic [DIV_W-1:0]  cfg_half,
  output logic              busy,
  output logic              valid,
  output logic              error,
  output logic [DATA_W-1:0] result,
  output logic              cnv,
  output logic              sdi,
  output logic              sck,
  input  logic              sdo
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  rd_state_t        st_q, st_d;
  logic             cnv_q, cnv_d;
  logic             sdi_q, sdi_d;
  logic             sck_q, sck_d;
  logic             err_q, err_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  logic             tmr_clr, tmr_en;
  logic [CNT_W-1:0] tmr_cnt;
  logic             div_clr, div_en, div_tick;
  logic             sh_en;
  logic             hold_hit, tmo_hit;

  sar_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .cnt   (tmr_cnt)
  );

  sar_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (div_clr),
    .en    (div_en),
    .half  (cfg_half),
    .tick  (div_tick)
  );

  sar_rd_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (sh_en),
    .din   (sdo),
    .q     (result)
  );

  // timer holds the number of edges since cnv rose
  assign hold_hit = ((CNT_W+1)'(tmr_cnt) + (CNT_W+1)'(1)) >= (CNT_W+1)'(cfg_sdi_hold);
  assign tmo_hit  = ((CNT_W+1)'(tmr_cnt) + (CNT_W+1)'(1)) >= (CNT_W+1)'(cfg_conv_max);

  always_comb begin
    st_d    = st_q;
    cnv_d   = cnv_q;
    sdi_d   = sdi_q;
    sck_d   = sck_q;
    err_d   = err_q;
    bit_d   = bit_q;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    div_clr = 1'b0;
    div_en  = 1'b0;
    sh_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_SEL;
          cnv_d   = 1'b1;
          sdi_d   = 1'b1;
          err_d   = 1'b0;
          tmr_clr = 1'b1;
        end
      end
      ST_SEL: begin
        tmr_en = 1'b1;
        if (hold_hit) begin
          st_d  = ST_WAIT;
          sdi_d = 1'b0;
        end
      end
      ST_WAIT: begin
        tmr_en = 1'b1;
        if (!sdo) begin
          st_d    = ST_READ;
          sck_d   = 1'b1;
          bit_d   = '0;
          div_clr = 1'b1;
        end else if (tmo_hit) begin
          st_d  = ST_RELSDI;
          sdi_d = 1'b1;
          err_d = 1'b1;
        end
      end
      ST_READ: begin
        div_en = 1'b1;
        if (div_tick) begin
          if (sck_q) begin
            sck_d = 1'b0;
          end else begin
            sh_en = 1'b1;
            if (bit_q == LAST_BIT) begin
              st_d  = ST_RELSDI;
              sdi_d = 1'b1;
            end else begin
              sck_d = 1'b1;
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_RELSDI: begin
        st_d  = ST_DROP;
        cnv_d = 1'b0;
      end
      ST_DROP: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= ST_IDLE;
      cnv_q <= 1'b0;
      sdi_q <= 1'b1;
      sck_q <= 1'b0;
      err_q <= 1'b0;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      cnv_q <= cnv_d;
      sdi_q <= sdi_d;
      sck_q <= sck_d;
      err_q <= err_d;
      bit_q <= bit_d;
    end
  end

  assign cnv   = cnv_q;
  assign sdi   = sdi_q;
  assign sck   = sck_q;
  assign busy  = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign valid = (st_q == ST_DONE) && !err_q;
  assign error = (st_q == ST_DONE) && err_q;

endmodule

// File: rtl/sar_rd_ctrl_chk.sv
module sar_rd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic valid,
  input logic error,
  input logic cnv,
  input logic sdi,
  input logic sck
);

  // chip-select mode needs sdi high when cnv rises
  assert_sdi_high_at_cnv_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> sdi);

  // serial clock only while converting and with select low
  assert_sck_inside_readout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (cnv && !sdi));

  // cnv only falls one cycle after sdi has returned high
  assert_cnv_falls_after_sdi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv) |-> (sdi && $past(sdi)));

  // strobes last one cycle
  assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_error_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  // strobe comes with cnv already low
  assert_strobe_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid || error) |-> (!cnv && sdi && !sck));

  assert_not_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && error));

  assert_idle_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid || error) |-> !busy);

  // converter line only active while busy
  assert_cnv_implies_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> busy);

endmodule

bind sar_rd_ctrl sar_rd_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .valid (valid),
  .error (error),
  .cnv   (cnv),
  .sdi   (sdi),
  .sck   (sck)
);

// File: tb/tb_sar_rd_ctrl.sv
module tb_sar_rd_ctrl;

  localparam int W     = 18;
  localparam int CNT_W = 12;
  localparam int DIV_W = 8;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [CNT_W-1:0] cfg_sdi_hold;
  logic [CNT_W-1:0] cfg_conv_max;
  logic [DIV_W-1:0] cfg_half;
  logic             busy, valid, error;
  logic [W-1:0]     result;
  logic             cnv, sdi, sck;
  logic             sdo;

  sar_rd_ctrl #(.DATA_W(W), .CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_sdi_hold(cfg_sdi_hold), .cfg_conv_max(cfg_conv_max), .cfg_half(cfg_half),
    .busy(busy), .valid(valid), .error(error), .result(result),
    .cnv(cnv), .sdi(sdi), .sck(sck), .sdo(sdo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [W-1:0] data;
    bit           err;
    int           lat;
  } exp_t;
  exp_t exp_q[$];

  int n_chk  = 0;
  int n_fail = 0;
  int t_mark = 0;
  int sck_hi = 0;
  int n_seen = 0;
  bit done   = 0;

  // device model settings
  logic [W-1:0] dev_data;
  int           dev_delay;
  bit           dev_glitch;
  int           dev_hold;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // sck high-cycle counter
  always @(negedge clk) if (rst_n && sck) sck_hi++;

  // converter model
  initial begin
    sdo = 1'b1;
    forever begin
      @(posedge cnv);
      check(sdi == 1'b1, "R2", "sdi at cnv rise", sdi, 1);
      begin
        int n;
        n = 0;
        if (dev_glitch) begin
          @(negedge clk) sdo = 1'b0;
          @(negedge clk) sdo = 1'b1;
          n = 2;
        end
        @(negedge clk);
        while (sdi) begin
          n++;
          @(negedge clk);
        end
        check(n == dev_hold, "R3", "sdi high cycles", n, dev_hold);
      end
      if (dev_delay < 0) begin
        @(posedge sdi);
      end else begin
        repeat (dev_delay) @(negedge clk);
        check(sdi == 1'b0, "R3", "sdi low at completion", sdi, 0);
        sdo    = 1'b0;
        t_mark = cyc;
        for (int b = W - 1; b >= 0; b--) begin
          @(negedge sck);
          sdo = dev_data[b];
        end
        @(posedge sdi);
        sdo = 1'b1;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (valid || error)) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected result", n_seen, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(error == e.err, "R8", "error strobe", error, e.err);
        check(valid == !e.err, "R7", "valid strobe", valid, !e.err);
        if (!e.err) check(result == e.data, "R6", "result word", result, e.data);
        check((cyc - t_mark) == e.lat, e.err ? "R8" : "R7", "strobe latency",
              cyc - t_mark, e.lat);
      end
    end
  end

  task automatic run(input logic [W-1:0] data, input int hold, input int half,
                     input int delay, input bit glitch, input bit poke);
    exp_t e;
    int   h;
    h           = (half == 0) ? 1 : half;
    dev_data    = data;
    dev_delay   = delay;
    dev_glitch  = glitch;
    dev_hold    = hold;
    cfg_sdi_hold = CNT_W'(hold);
    cfg_half    = DIV_W'(half);
    sck_hi      = 0;
    e.data      = data;
    e.err       = (delay < 0);
    e.lat       = e.err ? (int'(cfg_conv_max) + 3) : (36 * h + 3);
    @(negedge clk);
    start = 1'b1;
    if (e.err) t_mark = cyc;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && cnv == 1'b1, "R2", "busy/cnv after start", {busy, cnv}, 3);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!(valid || error)) @(negedge clk);
    check(sck_hi == (e.err ? 0 : 18 * h), e.err ? "R8" : "R5", "sck high cycles",
          sck_hi, e.err ? 0 : 18 * h);
    check(busy == 1'b0, "R9", "busy during strobe", busy, 0);
    @(negedge clk);
    check(busy == 0 && cnv == 0 && sdi == 1 && sck == 0, "R9", "idle after strobe",
          {busy, cnv, sdi, sck}, 2);
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    rst_n        = 1'b0;
    start        = 1'b0;
    cfg_sdi_hold = CNT_W'(2);
    cfg_conv_max = CNT_W'(200);
    cfg_half     = DIV_W'(1);
    dev_data     = '0;
    dev_delay    = 0;
    dev_glitch   = 0;
    dev_hold     = 2;
    repeat (3) @(negedge clk);
    check(cnv == 0 && sdi == 1 && sck == 0, "R1", "lines in reset", {cnv, sdi, sck}, 2);
    check(busy == 0 && valid == 0 && error == 0, "R1", "status in reset",
          {busy, valid, error}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cnv == 0 && sdi == 1 && sck == 0 && busy == 0, "R1", "idle after reset",
          {cnv, sdi, sck, busy}, 2);

    run(18'h2AAAA, 2, 1, 10, 0, 0);   // R5 R6 R7 alternating bits
    run(18'h15555, 1, 2, 5, 0, 0);    // R3 minimum hold
    run(18'h3FFFF, 3, 3, 12, 0, 0);   // all ones
    run(18'h00000, 4, 0, 8, 0, 0);    // R5 half of 0 acts as 1
    run(18'h20001, 6, 1, 6, 1, 0);    // R4 early low on sdo ignored
    run(18'h1B3C5, 2, 2, 15, 0, 1);   // R2 start while busy ignored
    cfg_conv_max = CNT_W'(20);
    run(18'h00000, 3, 1, -1, 0, 0);   // R8 timeout
    cfg_conv_max = CNT_W'(200);
    run(18'h0F0F0, 2, 1, 7, 0, 0);    // R9 recovery after timeout

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2", "pending expectations", exp_q.size(), 0);
    check(n_seen == 8, "R2", "results seen", n_seen, 8);
    done = 1;
    finish_up();
  end

endmodule